// File: doc/BRIEF.md
# Big-endian load/store lane unit

This unit sits between a core's memory stage and a 32-bit word-wide data memory. It supports byte, halfword and word accesses. On the request side it adds a sign-extended 16-bit displacement to a base value to form a byte address. From that address it drives the memory with a word-aligned address, four byte-enables and store data placed in the right byte lanes. Lane selection is big-endian: the lowest byte address maps to the most significant byte of the memory word.

The memory returns read data one cycle after it accepts a read. The unit keeps the size, lane offset and signedness of each accepted load for that cycle. It then cuts the addressed byte or halfword out of the returned word and widens it to 32 bits, with either sign or zero extension. A halfword or word access that is not naturally aligned raises a misalignment flag, and the unit then issues nothing to the memory.

Top module: `lsu_lane_be`

## Requirements
- R1: The effective address is base_addr plus the 16-bit displacement sign-extended to 32 bits. mem_addr carries the effective address with bits 1:0 forced to zero.
- R2: The size encoding is 0 for byte, 1 for halfword, 2 for word; code 3 behaves as word. mem_be bit i enables memory bits 8i+7:8i. An aligned byte access at address bits 1:0 = k sets only mem_be bit 3-k.
- R3: An aligned halfword access sets mem_be to 4'b1100 when address bit 1 is 0, and to 4'b0011 when it is 1.
- R4: A word access sets mem_be to 4'b1111 and mem_wdata to store_data unchanged.
- R5: A byte store copies store_data[7:0] into all four lanes of mem_wdata. A halfword store copies store_data[15:0] into both halves. The upper register bits never reach memory.
- R6: A halfword access with address bit 0 set raises misalign, and so does a word access with address bits 1:0 nonzero. A byte access never does. While misalign is 1, mem_be is 0 and mem_req and mem_we are 0. With req_valid low, misalign, mem_be, mem_req and mem_we are all 0.
- R7: load_valid is 1 in exactly the cycle after an accepted load: req_valid high, req_we low and no misalign. It stays 0 after stores, misaligned requests and idle cycles.
- R8: A signed byte load (req_unsigned=0) returns the byte at offset k, taken from mem_rdata bits 31-8k:24-8k, sign-extended to 32 bits.
- R9: An unsigned byte or halfword load (req_unsigned=1) zero-fills bits above the loaded value.
- R10: A halfword load returns mem_rdata[31:16] for offset 0 and mem_rdata[15:0] for offset 2. When req_unsigned is 0 the value is sign-extended.
- R11: A word load returns mem_rdata unchanged, whatever the value of req_unsigned.
- R12: After reset, load_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_unsigned | input | 1 | Zero-extend a narrow load |
| base_addr | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_data | input | 32 | Source register for stores |
| mem_req | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables, bit 3 is bits 31:24 |
| mem_wdata | output | 32 | Lane-placed store data |
| misalign | output | 1 | Misaligned access flag |
| mem_rdata | input | 32 | Read word, one cycle after the request |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |

## Verification
The bench goes after lane order at every offset. A little-endian mapping would enable bit k instead of bit 3-k and would return the wrong byte. It checks the extension boundary with values whose top bit is set. A swapped signed/unsigned decode, or extension from the wrong bit, would show up there as wrong upper bits. It also tests every size against every pair of low address bits. A design that flagged bytes, or missed an odd halfword, would either issue a torn access or block a legal one. Displacements of both signs check that the displacement is sign-extended and not zero-extended.

// File: rtl/lsu_lane_be.sv
module lsu_lane_be #(
  parameter int DW = 32,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [1:0]    req_size,
  input  logic          req_unsigned,
  input  logic [DW-1:0] base_addr,
  input  logic [OW-1:0] disp,
  input  logic [DW-1:0] store_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [DW-1:0] mem_wdata,
  output logic          misalign,
  input  logic [DW-1:0] mem_rdata,
  output logic          load_valid,
  output logic [DW-1:0] load_data
);
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;

  logic [DW-1:0] ea;
  logic          bad;
  logic [3:0]    be_raw;
  logic [1:0]    ld_size, ld_off;
  logic          ld_uns;
  logic [7:0]    rb;
  logic [15:0]   rh;

  assign ea       = base_addr + {{(DW-OW){disp[OW-1]}}, disp};
  assign mem_addr = {ea[DW-1:2], 2'b00};

  always_comb begin
    case (req_size)
      SZ_B:    bad = 1'b0;
      SZ_H:    bad = ea[0];
      default: bad = |ea[1:0];
    endcase
  end

  always_comb begin
    case (req_size)
      SZ_B:    be_raw = 4'b1000 >> ea[1:0];
      SZ_H:    be_raw = ea[1] ? 4'b0011 : 4'b1100;
      default: be_raw = 4'b1111;
    endcase
  end

  assign misalign = req_valid & bad;
  assign mem_req  = req_valid & ~bad;
  assign mem_we   = mem_req & req_we;
  assign mem_be   = mem_req ? be_raw : 4'b0000;

  always_comb begin
    case (req_size)
      SZ_B:    mem_wdata = {4{store_data[7:0]}};
      SZ_H:    mem_wdata = {2{store_data[15:0]}};
      default: mem_wdata = store_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_valid <= 1'b0;
      ld_size    <= 2'd0;
      ld_off     <= 2'd0;
      ld_uns     <= 1'b0;
    end else begin
      load_valid <= mem_req & ~req_we;
      if (mem_req && !req_we) begin
        ld_size <= req_size;
        ld_off  <= ea[1:0];
        ld_uns  <= req_unsigned;
      end
    end
  end

  assign rb = 8'(mem_rdata >> {~ld_off, 3'b000});
  assign rh = ld_off[1] ? mem_rdata[15:0] : mem_rdata[31:16];

  always_comb begin
    case (ld_size)
      SZ_B:    load_data = {{(DW-8){rb[7] & ~ld_uns}}, rb};
      SZ_H:    load_data = {{(DW-16){rh[15] & ~ld_uns}}, rh};
      default: load_data = mem_rdata;
    endcase
  end

  p_misalign_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_be == 4'b0000 && !mem_req && !mem_we));
  p_byte_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_size == 2'd0) |-> $countones(mem_be) == 1);
  p_byte_never_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd0) |-> !misalign);
  p_load_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !req_we) |=> load_valid);
  p_no_spurious_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && !req_we) |=> !load_valid);
  p_ubyte_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !req_we && req_size == 2'd0 && req_unsigned) |=> load_data[31:8] == 24'd0);
endmodule

// File: tb/tb_lsu_lane_be.sv
module tb_lsu_lane_be;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] base_addr = 32'd0, store_data = 32'd0, mem_rdata = 32'd0;
  logic [15:0] disp = 16'd0;
  logic        mem_req, mem_we, misalign, load_valid;
  logic [31:0] mem_addr, mem_wdata, load_data;
  logic [3:0]  mem_be;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lsu_lane_be dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  function automatic logic [3:0] exp_be(input int sz, input int k);
    if (sz == 0) return 4'(1 << (3 - k));
    if (sz == 1) return (k >= 2) ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic bit exp_bad(input int sz, input int k);
    if (sz == 0) return 0;
    if (sz == 1) return (k % 2) != 0;
    return k != 0;
  endfunction

  function automatic logic [31:0] exp_load(input int sz, input int k, input bit uns, input logic [31:0] w);
    logic [31:0] v;
    if (sz == 0) begin
      v = (w >> (8 * (3 - k))) & 32'hFF;
      if (!uns && v[7]) v = v | 32'hFFFF_FF00;
    end else if (sz == 1) begin
      v = (w >> (16 * (1 - k / 2))) & 32'hFFFF;
      if (!uns && v[15]) v = v | 32'hFFFF_0000;
    end else v = w;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #12;
    chk("R12 load_valid after reset", {31'd0, load_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 load_valid idle", {31'd0, load_valid}, 32'd0);
    chk("R6 idle be", {28'd0, mem_be}, 32'd0);
    chk("R6 idle req", {30'd0, mem_req, misalign}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] b; logic [15:0] d;
      b = 32'h1000_0000 + 32'h0001_3579 * 32'(i);
      d = (i % 2) ? 16'(16'hFFFF - 16'(i * 37)) : 16'(i * 1234);
      @(negedge clk);
      req_valid = 1; req_we = 1; req_size = 2'd0; base_addr = b; disp = d;
      #1;
      chk("R1 mem_addr", mem_addr, (b + 32'($signed(d))) & 32'hFFFF_FFFC);
    end

    for (int sz = 0; sz < 4; sz++)
      for (int k = 0; k < 4; k++)
        for (int p = 0; p < 3; p++) begin
          logic [31:0] sd; bit bad;
          sd = 32'h9E37_79B9 * 32'(p + 1 + 4 * k + 16 * sz);
          bad = exp_bad(sz, k);
          @(negedge clk);
          req_valid = 1; req_we = 1; req_size = 2'(sz); store_data = sd;
          base_addr = 32'h0000_4000 + 32'(k); disp = 16'h0010;
          #1;
          chk($sformatf("R6 misalign sz%0d k%0d", sz, k), {31'd0, misalign}, {31'd0, bad});
          chk($sformatf("R6 mem_we sz%0d k%0d", sz, k), {31'd0, mem_we}, {31'd0, !bad});
          if (bad) chk("R6 be cleared", {28'd0, mem_be}, 32'd0);
          else begin
            chk(sz == 0 ? "R2 byte be" : sz == 1 ? "R3 half be" : "R4 word be",
                {28'd0, mem_be}, {28'd0, exp_be(sz, k)});
            if (sz == 0) chk("R5 byte data", mem_wdata, (sd & 32'hFF) * 32'h0101_0101);
            else if (sz == 1) chk("R5 half data", mem_wdata, (sd & 32'hFFFF) * 32'h0001_0001);
            else chk("R4 word data", mem_wdata, sd);
          end
          @(negedge clk);
          req_valid = 0;
          #1;
          chk("R7 no load after store", {31'd0, load_valid}, 32'd0);
        end

    for (int sz = 0; sz < 4; sz++)
      for (int k = 0; k < 4; k++)
        for (int u = 0; u < 2; u++)
          for (int p = 0; p < 3; p++) begin
            logic [31:0] w; bit bad;
            w = (p == 0) ? 32'h80FF_7F01 : (p == 1) ? 32'h7F80_01FE : 32'hC3A5_5A3C ^ 32'(k * 17);
            bad = exp_bad(sz, k);
            @(negedge clk);
            req_valid = 1; req_we = 0; req_size = 2'(sz); req_unsigned = u[0];
            base_addr = 32'h0000_8010; disp = 16'(k) - 16'd16;
            #1;
            chk("R1 load addr", mem_addr, 32'h0000_8000);
            @(negedge clk);
            req_valid = 0; req_unsigned = ~u[0]; mem_rdata = w;
            #1;
            chk($sformatf("R7 load_valid sz%0d k%0d", sz, k), {31'd0, load_valid}, {31'd0, !bad});
            if (!bad)
              chk(sz == 0 ? (u ? "R9 ubyte" : "R8 sbyte") : sz == 1 ? (u ? "R9 uhalf" : "R10 shalf") : "R11 word",
                  load_data, exp_load(sz, k, u[0], w));
          end

    @(negedge clk);
    #1;
    chk("R7 idle no load", {31'd0, load_valid}, 32'd0);
    finish_run();
  end
endmodule